// File: doc/BRIEF.md
# SDRAM Write Burst Engine

This block produces the write side of an SDRAM burst. A WRITE command gives a bank and a starting column. From that clock onwards, the engine issues one burst slot per clock. Each slot carries a column address, the bank and the data beat, together with an array write enable that is cleared whenever the byte mask (DQM) was high for that beat. Bursts are 1, 2, 4 or 8 beats long, or they run over the whole page, and they can be cut short by a STOP (burst terminate) command or by a new READ or WRITE.

Inputs are sampled on the rising clock edge. The slot for a beat sampled on edge N appears on the outputs after edge N, so it is valid in the following cycle. The SDRAM data pins cannot be stalled, so there is no back-pressure: every beat in a burst is consumed on its clock whether or not it is written. The command, mask and status pins are plain, level-sampled signals.

Top module: `sdram_wr_burst`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after release with no command, `busy_o` and `wr_en_o` are low.
- R2: A WRITE (`cmd_i` = 2'b01) sampled on an edge gives, after that edge, `busy_o` high with `wr_col_o` = `col_i`, `wr_bank_o` = `bank_i` and `wr_data_o` = `din_i`, all from that same edge. The first beat is therefore taken together with the command.
- R3: A beat sampled with `dqm_i` high still uses up its burst slot (`busy_o` high), but `wr_en_o` is low. With `dqm_i` low in a slot, `wr_en_o` is high.
- R4: `bl_i` is latched at the WRITE. The value 0, 1, 2 or 3 gives a burst of 1, 2, 4 or 8 slots. While only NOP (`cmd_i` = 2'b00) follows, exactly that many consecutive slots are issued, and `busy_o` then falls.
- R5: In a fixed-length burst, the column advances by one per slot and wraps inside the block of burst-length size that holds the start column. For example, start 5 with length 4 gives 5, 6, 7, 4.
- R6: `bl_i` = 7 selects a full-page burst. The column increments modulo 2^COL_W and the burst never ends by itself.
- R7: A STOP (`cmd_i` = 2'b11) gives no slot for the beat sampled with it and ends the burst. The last beat written is therefore the one sampled on the edge before the STOP.
- R8: A WRITE sampled during a burst starts a new burst at once from its own bank and column. A READ (`cmd_i` = 2'b10) sampled during a burst ends it with no slot on that edge.
- R9: `busy_o` is high in exactly the cycles that carry a burst slot, from the WRITE beat through the last beat, and `wr_en_o` is never high without `busy_o`.
- R10: The `bl_i` values 4, 5 and 6 are reserved and behave as a burst of one slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 2 | Decoded command: 00 NOP, 01 WRITE, 10 READ, 11 STOP |
| bank_i | input | BANK_W | Bank for a WRITE |
| col_i | input | COL_W | Start column for a WRITE |
| bl_i | input | 3 | Burst length select, latched at a WRITE |
| din_i | input | DATA_W | Data beat sampled this clock |
| dqm_i | input | 1 | Beat mask, high suppresses the write |
| wr_en_o | output | 1 | Array write enable for the current slot |
| wr_bank_o | output | BANK_W | Bank of the current slot |
| wr_col_o | output | COL_W | Column of the current slot |
| wr_data_o | output | DATA_W | Data of the current slot |
| busy_o | output | 1 | A burst slot is on the outputs |

## Verification
The bench builds the engine with COL_W = 5, BANK_W = 2 and DATA_W = 16. The 32-column page means a full-page burst wraps past column 31 back to 0 within a few dozen cycles. The bench can therefore cover the page wrap, a STOP after the wrap, and the aligned-block wrap of every fixed length in short directed runs. With that narrow column range, random traffic also hits interrupted bursts near block and page boundaries often.

// File: rtl/wbe_pkg.sv
package wbe_pkg;
  typedef enum logic [1:0] {
    CMD_NOP   = 2'b00,
    CMD_WRITE = 2'b01,
    CMD_READ  = 2'b10,
    CMD_STOP  = 2'b11
  } wbe_cmd_e;

  localparam logic [2:0] BL_FULL = 3'd7;
endpackage

// File: rtl/wbe_len_decode.sv
module wbe_len_decode #(
  parameter int COL_W = 8
) (
  input  logic [2:0]       sel_i,
  output logic [COL_W-1:0] mask_o,
  output logic             full_o
);
  import wbe_pkg::*;

  // mask = burst length - 1; full page uses every column bit
  always_comb begin
    mask_o = '0;
    full_o = 1'b0;
    if (sel_i == BL_FULL) begin
      mask_o = '1;
      full_o = 1'b1;
    end else if (sel_i <= 3'd3) begin
      for (int b = 0; b < 3; b++)
        if (b < int'(sel_i) && b < COL_W) mask_o[b] = 1'b1;
    end
  end
endmodule

// File: rtl/wbe_col_step.sv
module wbe_col_step #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] cur_i,
  input  logic [COL_W-1:0] mask_i,
  output logic [COL_W-1:0] next_o
);
  logic [COL_W-1:0] inc;
  assign inc    = cur_i + 1'b1;
  assign next_o = (cur_i & ~mask_i) | (inc & mask_i);
endmodule

// File: rtl/wbe_burst_ctl.sv
module wbe_burst_ctl #(
  parameter int COL_W  = 8,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cmd_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [COL_W-1:0]  mask_i,
  input  logic              full_i,
  output logic              slot_o,
  output logic [COL_W-1:0]  slot_col_o,
  output logic [BANK_W-1:0] slot_bank_o
);
  import wbe_pkg::*;

  logic              act_q, full_q;
  logic [COL_W-1:0]  col_q, mask_q, remain_q, step_col;
  logic [BANK_W-1:0] bank_q;
  wbe_cmd_e          cmd;

  assign cmd = wbe_cmd_e'(cmd_i);

  wbe_col_step #(.COL_W(COL_W)) u_step (
    .cur_i (col_q),
    .mask_i(mask_q),
    .next_o(step_col)
  );

  always_comb begin
    slot_o      = 1'b0;
    slot_col_o  = step_col;
    slot_bank_o = bank_q;
    unique case (cmd)
      CMD_WRITE: begin
        slot_o      = 1'b1;
        slot_col_o  = col_i;
        slot_bank_o = bank_i;
      end
      CMD_NOP: slot_o = act_q;
      default: slot_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q    <= 1'b0;
      full_q   <= 1'b0;
      col_q    <= '0;
      mask_q   <= '0;
      remain_q <= '0;
      bank_q   <= '0;
    end else begin
      unique case (cmd)
        CMD_WRITE: begin
          act_q    <= full_i || (mask_i != '0);
          full_q   <= full_i;
          col_q    <= col_i;
          mask_q   <= mask_i;
          remain_q <= mask_i;
          bank_q   <= bank_i;
        end
        CMD_NOP: begin
          if (act_q) begin
            col_q <= step_col;
            if (!full_q) begin
              remain_q <= remain_q - 1'b1;
              act_q    <= (remain_q > 1);
            end
          end
        end
        default: act_q <= 1'b0;
      endcase
    end
  end

  // R4
  remain_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !full_q) |-> (remain_q != '0));

  // R8
  read_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_READ) |=> !act_q);
endmodule

// File: rtl/sdram_wr_burst.sv
module sdram_wr_burst #(
  parameter int COL_W  = 8,
  parameter int BANK_W = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cmd_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [2:0]        bl_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic              dqm_i,
  output logic              wr_en_o,
  output logic [BANK_W-1:0] wr_bank_o,
  output logic [COL_W-1:0]  wr_col_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              busy_o
);
  import wbe_pkg::*;

  logic [COL_W-1:0]  mask;
  logic              full;
  logic              slot;
  logic [COL_W-1:0]  slot_col;
  logic [BANK_W-1:0] slot_bank;

  wbe_len_decode #(.COL_W(COL_W)) u_dec (
    .sel_i (bl_i),
    .mask_o(mask),
    .full_o(full)
  );

  wbe_burst_ctl #(.COL_W(COL_W), .BANK_W(BANK_W)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_i      (cmd_i),
    .bank_i     (bank_i),
    .col_i      (col_i),
    .mask_i     (mask),
    .full_i     (full),
    .slot_o     (slot),
    .slot_col_o (slot_col),
    .slot_bank_o(slot_bank)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en_o   <= 1'b0;
      busy_o    <= 1'b0;
      wr_col_o  <= '0;
      wr_bank_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o   <= slot && !dqm_i;
      busy_o    <= slot;
      wr_col_o  <= slot_col;
      wr_bank_o <= slot_bank;
      wr_data_o <= din_i;
    end
  end

  // R9
  en_within_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> busy_o);

  // R7
  stop_drops_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == CMD_STOP) |=> (!busy_o && !wr_en_o));

  // R2
  write_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == CMD_WRITE) |=> (busy_o && wr_col_o == $past(col_i)
                              && wr_bank_o == $past(bank_i)));

  // R3
  mask_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dqm_i |=> !wr_en_o);
endmodule

// File: tb/tb_sdram_wr_burst.sv
`timescale 1ns/1ps
module tb_sdram_wr_burst;
  localparam int COL_W  = 5;
  localparam int BANK_W = 2;
  localparam int DATA_W = 16;
  localparam int PAGE   = 1 << COL_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        cmd = 2'b00;
  logic [BANK_W-1:0] bank = '0;
  logic [COL_W-1:0]  col = '0;
  logic [2:0]        bl = 3'd0;
  logic [DATA_W-1:0] din = '0;
  logic              dqm = 1'b0;
  logic              wr_en, busy;
  logic [BANK_W-1:0] wr_bank;
  logic [COL_W-1:0]  wr_col;
  logic [DATA_W-1:0] wr_data;

  int checks = 0, errors = 0, cyc = 0;

  // reference model state
  bit m_act = 0;
  int m_start, m_k, m_len, m_bank;
  bit e_busy = 0, e_en = 0;
  int e_col, e_bank, e_data;

  always #2 clk = ~clk;

  sdram_wr_burst #(.COL_W(COL_W), .BANK_W(BANK_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .bank_i(bank), .col_i(col),
    .bl_i(bl), .din_i(din), .dqm_i(dqm), .wr_en_o(wr_en),
    .wr_bank_o(wr_bank), .wr_col_o(wr_col), .wr_data_o(wr_data),
    .busy_o(busy));

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic int len_of(input int sel);
    if (sel == 7) return 0;
    if (sel <= 3) return 1 << sel;
    return 1;
  endfunction

  function automatic int col_at(input int start, input int k, input int len);
    if (len == 0) return (start + k) % PAGE;
    return (start & ~(len - 1)) | ((start + k) & (len - 1));
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(busy == e_busy, tag, "busy", busy, e_busy);
    chk(wr_en == e_en, tag, "wr_en", wr_en, e_en);
    if (e_busy) begin
      chk(wr_col == e_col, tag, "col", wr_col, e_col);
      chk(wr_bank == e_bank, tag, "bank", wr_bank, e_bank);
    end
    if (e_en) chk(wr_data == e_data, tag, "data", wr_data, e_data);
  endtask

  // check the previous cycle's result, then drive one new clock of stimulus
  task automatic step(input string tag, input int c, input int b, input int s,
                      input int sel, input bit m);
    int d;
    @(negedge clk);
    compare(tag);
    d = int'($urandom_range(0, 65535));
    cmd = c[1:0]; bank = b[BANK_W-1:0]; col = s[COL_W-1:0];
    bl = sel[2:0]; dqm = m; din = d[DATA_W-1:0];
    e_busy = 0; e_en = 0; e_data = d;
    case (c)
      1: begin
        m_len = len_of(sel); m_start = s; m_k = 0; m_bank = b;
        m_act = (m_len != 1);
        e_busy = 1; e_en = !m; e_col = s; e_bank = b;
      end
      0: if (m_act) begin
        m_k++;
        e_busy = 1; e_en = !m; e_bank = m_bank;
        e_col = col_at(m_start, m_k, m_len);
        m_act = (m_len == 0) || (m_k < m_len - 1);
      end
      default: m_act = 0;
    endcase
  endtask

  task automatic nops(input string tag, input int n, input bit m);
    for (int i = 0; i < n; i++) step(tag, 0, 0, 0, 0, m);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1: outputs idle under reset
    chk(busy == 0, "R1", "busy in reset", busy, 0);
    chk(wr_en == 0, "R1", "wr_en in reset", wr_en, 0);
    rst_n = 1'b1;
    nops("R1", 2, 0);

    // R2 / R4: every fixed length from an aligned start
    for (int sel = 0; sel < 4; sel++) begin
      step("R2", 1, sel, 8, sel, 0);
      nops("R4", 10, 0);
    end
    // R5: misaligned starts wrap inside their aligned block
    step("R5", 1, 1, 5, 2, 0);  nops("R5", 5, 0);
    step("R5", 1, 2, 14, 3, 0); nops("R5", 9, 0);
    step("R5", 1, 3, 31, 1, 0); nops("R5", 3, 0);
    // R3: masked beats keep their slot but are not written
    step("R3", 1, 0, 0, 3, 1);
    for (int i = 0; i < 8; i++) step("R3", 0, 0, 0, 0, i[0]);
    // R6 / R7: full page wraps, then STOP drops its own beat
    step("R6", 1, 2, 28, 7, 0);
    nops("R6", 40, 0);
    step("R7", 3, 0, 0, 0, 0);
    nops("R7", 3, 0);
    // R7: STOP inside a burst of eight
    step("R7", 1, 1, 16, 3, 0); nops("R7", 2, 0);
    step("R7", 3, 0, 0, 0, 0);  nops("R7", 4, 0);
    // R8: WRITE and READ interrupting a burst
    step("R8", 1, 0, 3, 3, 0); nops("R8", 2, 0);
    step("R8", 1, 3, 21, 2, 0); nops("R8", 1, 0);
    step("R8", 2, 0, 0, 0, 0);  nops("R8", 3, 0);
    // R10: reserved length codes
    for (int sel = 4; sel < 7; sel++) begin
      step("R10", 1, 1, 9, sel, 0);
      nops("R10", 3, 0);
    end
    // R9: random command traffic, busy tracks every slot
    for (int i = 0; i < 3000; i++) begin
      int r, c, sel;
      r = int'($urandom_range(0, 15));
      c = (r < 2) ? 1 : (r == 2) ? 2 : (r == 3) ? 3 : 0;
      case ($urandom_range(0, 5))
        0: sel = 0; 1: sel = 1; 2: sel = 2; 3: sel = 3; 4: sel = 7;
        default: sel = 5;
      endcase
      step("R9", c, int'($urandom_range(0, 3)), int'($urandom_range(0, PAGE-1)),
           sel, ($urandom_range(0, 3) == 0));
    end
    nops("R9", 2, 0);
    @(negedge clk);
    compare("R9");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule